// File: doc/BRIEF.md
# Parallel GPIO Port with Edge and Level Interrupts

This block is a general-purpose I/O peripheral for up to 32 pins, reached over a simple register bus with byte strobes. All pins form one parallel port. A single full-word write updates every output bit in the same clock cycle. Narrower writes with a subset of the byte strobes change only the bytes or halfwords they select. Each pin has its own configuration bits: input enable, output enable, output level, pull-up enable, drive strength, output inversion, and an override that hands the pin to one of two hardware function sources.

Incoming pin levels are synchronised before they are used. Software can read them as one word. Four independent detectors watch each synchronised pin: rising edge, falling edge, high level and low level. Each detector has its own enable and pending register. A pending bit is cleared by writing 1 to it. All pending bits combine into a single interrupt line.

Top module: `gpio_port`

## Requirements
- R1: A word write at offset 0x0C (output level) with all four byte strobes set changes every pin's output in the cycle after the write edge (no override, no inversion).
- R2: Byte strobe b (bit b of the 4-bit strobe) updates bits 8b+7..8b of the addressed register; bytes whose strobe is 0 keep their value, so 8- and 16-bit writes change only their lanes.
- R3: Pin levels pass two register stages: a change applied before a rising edge reads back at offset 0x00 after the second rising edge. Bits whose input enable (offset 0x04) is 0 read as 0. Writes to 0x00 have no effect.
- R4: With rise enable (0x18) and input enable set for a pin, a 0-to-1 pin change sets that pin's bit in the rise pending register (0x1C). The bit is visible after the third rising edge following the change.
- R5: With fall enable (0x20) set, a 1-to-0 pin change sets the bit at fall pending (0x24), with the same three-edge latency as R4.
- R6: With high enable (0x28) set and the pin high, the bit at high pending (0x2C) sets one edge after the enable is written. After a 1-write clears it, the bit reads 0 for one cycle and sets again on the next edge while the level persists.
- R7: With low enable (0x30) set and the pin low, the bit at low pending (0x34) sets one edge later.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A pending bit never sets while its enable bit or the pin's input enable is 0.
- R9: The output `irq` is 1 exactly when some bit of the four pending registers is 1.
- R10: When bit i of the override enable (0x38) is 1, pin i takes `altFuncA[i]` if bit i of the override select (0x3C) is 0, and `altFuncB[i]` if it is 1. Otherwise the pin takes bit i of the output level register.
- R11: `padOut` is the source chosen in R10 XORed with the inversion register (0x40).
- R12: `padOe` equals the output enable register (0x08), `padPullEn` equals the pull-up register (0x10), and `padDrive` equals the drive register (0x14).
- R13: After reset, every register reads 0 except drive, which reads the DRIVE_RESET parameter (all ones by default). Offsets at or above 0x44 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address; bits above 1 pick the register |
| busStrb | input | 4 | Byte write strobes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address during a read |
| padIn | input | PIN_COUNT | Raw pin levels |
| padOut | output | PIN_COUNT | Value driven to each pin |
| padOe | output | PIN_COUNT | Output driver enable per pin |
| padPullEn | output | PIN_COUNT | Pull-up enable per pin |
| padDrive | output | PIN_COUNT | Drive strength per pin |
| altFuncA | input | PIN_COUNT | First hardware function source |
| altFuncB | input | PIN_COUNT | Second hardware function source |
| irq | output | 1 | OR of all pending bits |

## Verification
Register writes take effect at the write edge, so output pins and read-back are checked at the following falling edge. The pin sample is due two edges after a pin change, and edge and level pending bits are due one edge after that. The bench reads at the falling edges before these points and checks that the old value is still there, then reads again at the exact edge where the new value is due. Level pending bits that re-set after a clear are checked at the cycle where they read 0 and at the next cycle where they read 1.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BUS_W     = 32;
  localparam int STRB_W    = BUS_W / 8;
  localparam int REG_COUNT = 17;
  localparam int IDX_W     = 5;

  // Word index of each register; each pending register sits right after its enable.
  typedef enum logic [IDX_W-1:0] {
    RG_PIN_IN    = 5'd0,
    RG_IN_EN     = 5'd1,
    RG_OUT_EN    = 5'd2,
    RG_OUT_VAL   = 5'd3,
    RG_PULL      = 5'd4,
    RG_DRIVE     = 5'd5,
    RG_RISE_EN   = 5'd6,
    RG_RISE_PEND = 5'd7,
    RG_FALL_EN   = 5'd8,
    RG_FALL_PEND = 5'd9,
    RG_HIGH_EN   = 5'd10,
    RG_HIGH_PEND = 5'd11,
    RG_LOW_EN    = 5'd12,
    RG_LOW_PEND  = 5'd13,
    RG_ALT_EN    = 5'd14,
    RG_ALT_SEL   = 5'd15,
    RG_OUT_INV   = 5'd16
  } regIdx_e;

  typedef struct packed {
    logic [REG_COUNT-1:0] wrHit;
    logic [BUS_W-1:0]     bitMask;
    logic                 rdHit;
    logic [IDX_W-1:0]     rdIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [STRB_W-1:0] busStrb,
  output ctrlStrobe_t       strobe
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]    wordIdx;
  logic                 mapped;
  logic [REG_COUNT-1:0] wrHit;
  logic [BUS_W-1:0]     bitMask;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign mapped  = (32'(wordIdx) < 32'(REG_COUNT));

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign bitMask[8*b +: 8] = {8{busStrb[b]}};
  end

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_hit
    assign wrHit[r] = busSel && busWrite && mapped && (32'(wordIdx) == r);
  end

  always_comb begin
    strobe.wrHit   = wrHit;
    strobe.bitMask = bitMask;
    strobe.rdHit   = busSel && !busWrite && mapped;
    strobe.rdIdx   = IDX_W'(wordIdx);
  end

  // R13: at most one register is targeted, and addresses past the map hit nothing
  assert_single_target_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrHit));
  assert_unmapped_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    (32'(busAddr) >= 32'h44) |-> (strobe.wrHit == '0 && !strobe.rdHit));
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int              PIN_COUNT   = 32,
  parameter logic [BUS_W-1:0] DRIVE_RESET = '1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [BUS_W-1:0]     busWdata,
  output logic [BUS_W-1:0]     busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] altFuncA,
  input  logic [PIN_COUNT-1:0] altFuncB,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullEn,
  output logic [PIN_COUNT-1:0] padDrive,
  output logic                 irq
);
  typedef logic [PIN_COUNT-1:0] pinVec_t;

  pinVec_t regFile  [REG_COUNT];
  pinVec_t condByReg[REG_COUNT];
  pinVec_t syncA, syncB, syncPrev;
  pinVec_t wMask, wData, clrMask;
  pinVec_t inEn, sampled, riseSeen, fallSeen, highSeen, lowSeen;
  pinVec_t outSrc, rdVal;

  function automatic logic isPend(input int r);
    return r == int'(RG_RISE_PEND) || r == int'(RG_FALL_PEND) ||
           r == int'(RG_HIGH_PEND) || r == int'(RG_LOW_PEND);
  endfunction

  assign wMask   = strobe.bitMask[PIN_COUNT-1:0];
  assign wData   = busWdata[PIN_COUNT-1:0];
  assign clrMask = wMask & wData;
  assign inEn    = regFile[RG_IN_EN];

  // Two-stage synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= padIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign sampled  = syncB & inEn;
  assign riseSeen = syncB & ~syncPrev & inEn;
  assign fallSeen = ~syncB & syncPrev & inEn;
  assign highSeen = syncB & inEn;
  assign lowSeen  = ~syncB & inEn;

  always_comb begin
    for (int r = 0; r < REG_COUNT; r++) condByReg[r] = '0;
    condByReg[RG_RISE_PEND] = riseSeen;
    condByReg[RG_FALL_PEND] = fallSeen;
    condByReg[RG_HIGH_PEND] = highSeen;
    condByReg[RG_LOW_PEND]  = lowSeen;
  end

  // Register file: plain registers merge by byte lane, pending registers are
  // set by their detector gated by the enable register just below them and
  // cleared by a 1-write, which wins in the cycle it lands.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < REG_COUNT; r++)
        regFile[r] <= (r == int'(RG_DRIVE)) ? DRIVE_RESET[PIN_COUNT-1:0] : '0;
    end else begin
      for (int r = 1; r < REG_COUNT; r++) begin
        if (isPend(r)) begin
          regFile[r] <= (regFile[r] | (condByReg[r] & regFile[r-1]))
                        & ~(strobe.wrHit[r] ? clrMask : '0);
        end else if (strobe.wrHit[r]) begin
          regFile[r] <= (regFile[r] & ~wMask) | (wData & wMask);
        end
      end
    end
  end

  // Per-pin output source selection and inversion
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    always_comb begin
      if (regFile[RG_ALT_EN][i])
        outSrc[i] = regFile[RG_ALT_SEL][i] ? altFuncB[i] : altFuncA[i];
      else
        outSrc[i] = regFile[RG_OUT_VAL][i];
    end
    assign padOut[i] = outSrc[i] ^ regFile[RG_OUT_INV][i];
  end

  assign padOe     = regFile[RG_OUT_EN];
  assign padPullEn = regFile[RG_PULL];
  assign padDrive  = regFile[RG_DRIVE];
  assign irq       = |{regFile[RG_RISE_PEND], regFile[RG_FALL_PEND],
                       regFile[RG_HIGH_PEND], regFile[RG_LOW_PEND]};

  always_comb begin
    rdVal = '0;
    if (strobe.rdHit) begin
      if (strobe.rdIdx == RG_PIN_IN) rdVal = sampled;
      else                          rdVal = regFile[strobe.rdIdx];
    end
  end
  assign busRdata = BUS_W'(rdVal);

  // R8: a newly set rise bit needs the enable and the input enable a cycle earlier
  assert_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((regFile[RG_RISE_PEND] & ~$past(regFile[RG_RISE_PEND]))
      & ~($past(regFile[RG_RISE_EN]) & $past(inEn))) == '0);
  // R8: a 1-write clears the level bit at that edge even when the level persists
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrHit[RG_HIGH_PEND] |=> (regFile[RG_HIGH_PEND] & $past(clrMask)) == '0);
  // R3: disabled inputs read as zero
  assert_input_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdHit && strobe.rdIdx == RG_PIN_IN) |-> (busRdata & ~BUS_W'(inEn)) == '0);
  // R1: a full-word write of the output level reaches the pins one edge later
  assert_word_update_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrHit[RG_OUT_VAL] && &wMask && regFile[RG_ALT_EN] == '0)
      |=> padOut == ($past(wData) ^ regFile[RG_OUT_INV]));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               PIN_COUNT   = 32,
  parameter int               ADDR_W      = 7,
  parameter logic [BUS_W-1:0] DRIVE_RESET = '1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [3:0]           busStrb,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullEn,
  output logic [PIN_COUNT-1:0] padDrive,
  input  logic [PIN_COUNT-1:0] altFuncA,
  input  logic [PIN_COUNT-1:0] altFuncB,
  output logic                 irq
);
  ctrlStrobe_t strobe;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busStrb (busStrb),
    .strobe  (strobe)
  );

  gpio_port_dp #(.PIN_COUNT(PIN_COUNT), .DRIVE_RESET(DRIVE_RESET)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .altFuncA (altFuncA),
    .altFuncB (altFuncB),
    .padOut   (padOut),
    .padOe    (padOe),
    .padPullEn(padPullEn),
    .padDrive (padDrive),
    .irq      (irq)
  );
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0, busWrite = 0;
  logic [6:0]  busAddr = '0;
  logic [3:0]  busStrb = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] padIn = '0, padOut, padOe, padPullEn, padDrive;
  logic [31:0] altFuncA = '0, altFuncB = '0;
  logic        irq;

  int errors = 0, checks = 0;
  logic [31:0] rv;
  logic [31:0] mOutVal, mOutInv, mAltEn, mAltSel, mOutEn, mPull, mDrive;

  always #4 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busStrb(busStrb), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .padPullEn(padPullEn), .padDrive(padDrive), .altFuncA(altFuncA),
    .altFuncB(altFuncB), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] s);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d; busStrb = s;
    @(negedge clk);
    busSel = 0; busWrite = 0; busStrb = '0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] s);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] expPad();
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = (mAltEn[i] ? (mAltSel[i] ? altFuncB[i] : altFuncA[i]) : mOutVal[i]) ^ mOutInv[i];
    return r;
  endfunction

  initial begin
    cyc(200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rstN = 1;
    cyc(1);
    // R13 reset state
    rd(7'h14, rv); check("R13 drive reset", rv, 32'hFFFF_FFFF);
    rd(7'h0C, rv); check("R13 outval reset", rv, 32'h0);
    check("R13 padOe reset", padOe, 32'h0);
    check("R13 irq reset", {31'b0, irq}, 32'h0);
    wr(7'h44, 32'hDEAD_BEEF, 4'hF);
    rd(7'h44, rv); check("R13 unmapped read", rv, 32'h0);
    check("R13 unmapped write no pin effect", padOut, 32'h0);

    // R1 / R12 word write
    wr(7'h08, 32'hFFFF_FFFF, 4'hF);
    check("R12 padOe", padOe, 32'hFFFF_FFFF);
    wr(7'h0C, 32'hA5A5_A5A5, 4'hF);
    check("R1 word write to pins", padOut, 32'hA5A5_A5A5);
    // R2 narrow writes
    wr(7'h0C, 32'hFFFF_FFFF, 4'b0010);
    rd(7'h0C, rv); check("R2 byte lane", rv, 32'hA5A5_FFA5);
    wr(7'h0C, 32'h0000_0000, 4'b1100);
    rd(7'h0C, rv); check("R2 halfword lane", rv, 32'h0000_FFA5);
    check("R2 pins follow", padOut, 32'h0000_FFA5);

    // R3 synchroniser latency and input mask
    wr(7'h04, 32'h0000_FFFF, 4'hF);
    padIn = 32'hFFFF_FFFF;
    rd(7'h00, rv); check("R3 no change at 0 edges", rv, 32'h0);
    cyc(1); rd(7'h00, rv); check("R3 no change at 1 edge", rv, 32'h0);
    cyc(1); rd(7'h00, rv); check("R3 masked sample at 2 edges", rv, 32'h0000_FFFF);
    wr(7'h00, 32'h0, 4'hF);
    rd(7'h00, rv); check("R3 read-only", rv, 32'h0000_FFFF);

    // R4 rise
    wr(7'h04, 32'hFFFF_FFFF, 4'hF);
    padIn = 32'h0;
    cyc(4);
    wr(7'h18, 32'h0000_000F, 4'hF);
    padIn = 32'h0000_00FF;
    cyc(2); rd(7'h1C, rv); check("R4 rise not yet", rv, 32'h0);
    cyc(1); rd(7'h1C, rv); check("R4 rise pending", rv, 32'h0000_000F);
    check("R9 irq on rise", {31'b0, irq}, 32'h1);
    // R8 w1c
    wr(7'h1C, 32'h0000_0001, 4'hF);
    rd(7'h1C, rv); check("R8 w1c one bit", rv, 32'h0000_000E);
    wr(7'h1C, 32'h0, 4'hF);
    rd(7'h1C, rv); check("R8 zero write keeps", rv, 32'h0000_000E);
    wr(7'h1C, 32'hFFFF_FFFF, 4'hF);
    check("R9 irq clear", {31'b0, irq}, 32'h0);

    // R5 fall
    wr(7'h20, 32'h0000_00F0, 4'hF);
    padIn = 32'h0;
    cyc(2); rd(7'h24, rv); check("R5 fall not yet", rv, 32'h0);
    cyc(1); rd(7'h24, rv); check("R5 fall pending", rv, 32'h0000_00F0);
    rd(7'h1C, rv); check("R4 no rise on fall", rv, 32'h0);
    wr(7'h24, 32'hFFFF_FFFF, 4'hF);
    wr(7'h20, 32'h0, 4'hF);

    // R8 input enable gating
    wr(7'h04, 32'hFFFF_FFEF, 4'hF);
    wr(7'h18, 32'h0000_0010, 4'hF);
    padIn = 32'h0000_0010;
    cyc(4);
    rd(7'h1C, rv); check("R8 disabled input no pend", rv, 32'h0);
    rd(7'h00, rv); check("R3 disabled bit reads 0", rv, 32'h0);
    wr(7'h04, 32'hFFFF_FFFF, 4'hF);
    wr(7'h18, 32'h0, 4'hF);

    // R6 high level
    padIn = 32'h0000_0110;
    cyc(3);
    wr(7'h28, 32'h0000_0100, 4'hF);
    rd(7'h2C, rv); check("R6 not yet", rv, 32'h0);
    cyc(1); rd(7'h2C, rv); check("R6 high pending", rv, 32'h0000_0100);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    wr(7'h2C, 32'h0000_0100, 4'hF);
    rd(7'h2C, rv); check("R6 cleared cycle", rv, 32'h0);
    cyc(1); rd(7'h2C, rv); check("R6 sets again", rv, 32'h0000_0100);
    wr(7'h28, 32'h0, 4'hF);
    wr(7'h2C, 32'hFFFF_FFFF, 4'hF);
    cyc(2); rd(7'h2C, rv); check("R8 disabled no pend", rv, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);

    // R7 low level
    wr(7'h30, 32'h0000_0200, 4'hF);
    cyc(1); rd(7'h34, rv); check("R7 low pending", rv, 32'h0000_0200);
    wr(7'h30, 32'h0, 4'hF);
    wr(7'h34, 32'hFFFF_FFFF, 4'hF);
    check("R9 irq all clear", {31'b0, irq}, 32'h0);

    // R10/R11 directed
    mOutVal = 32'h0; mOutInv = 32'h0; mAltEn = 32'h0000_00FF; mAltSel = 32'h0000_000F;
    mOutEn = 32'h0; mPull = 32'h0; mDrive = 32'hFFFF_FFFF;
    wr(7'h0C, mOutVal, 4'hF); wr(7'h40, mOutInv, 4'hF); wr(7'h08, mOutEn, 4'hF);
    wr(7'h38, mAltEn, 4'hF); wr(7'h3C, mAltSel, 4'hF);
    altFuncA = 32'h0000_0030; altFuncB = 32'h0000_0005;
    #1 check("R10 override select", padOut, 32'h0000_0035);
    mOutInv = 32'h8000_0001; wr(7'h40, mOutInv, 4'hF);
    check("R11 inversion", padOut, 32'h8000_0034);

    // Random output configuration
    for (int it = 0; it < 150; it++) begin
      int sel = $urandom_range(0, 6);
      logic [31:0] d = $urandom();
      logic [3:0]  s = 4'($urandom_range(1, 15));
      logic [6:0]  a;
      logic [31:0] exp;
      case (sel)
        0: begin a = 7'h0C; mOutVal = merge(mOutVal, d, s); exp = mOutVal; end
        1: begin a = 7'h40; mOutInv = merge(mOutInv, d, s); exp = mOutInv; end
        2: begin a = 7'h38; mAltEn  = merge(mAltEn,  d, s); exp = mAltEn;  end
        3: begin a = 7'h3C; mAltSel = merge(mAltSel, d, s); exp = mAltSel; end
        4: begin a = 7'h08; mOutEn  = merge(mOutEn,  d, s); exp = mOutEn;  end
        5: begin a = 7'h10; mPull   = merge(mPull,   d, s); exp = mPull;   end
        default: begin a = 7'h14; mDrive = merge(mDrive, d, s); exp = mDrive; end
      endcase
      wr(a, d, s);
      altFuncA = $urandom(); altFuncB = $urandom();
      #1;
      rd(a, rv); check("R2 random readback", rv, exp);
      check("R11 random padOut", padOut, expPad());
      check("R12 random padOe", padOe, mOutEn);
      check("R12 random pull", padPullEn, mPull);
      check("R12 random drive", padDrive, mDrive);
      cyc(1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule